// File: doc/BRIEF.md
# Error-Diffusion Halftone Pixel Unit

This block converts one grayscale pixel of `PIX_W` bits into a single halftone bit by error diffusion. Alongside the pixel it receives the signed quantization errors already computed for four neighbours. It forms a weighted average of these errors and adds it to the pixel. It then compares the corrected value with the mid-scale threshold. It returns the halftone bit and the new signed error for the current pixel. A surrounding controller keeps that error and hands it back when later pixels need it.

The unit does not scan the image or store any errors. Three position flags tell it when the pixel sits on the first row, the first column or the last column, and the unit then zeroes the neighbours that would fall outside the image. The four neighbour weights are elaboration parameters. When their total is a power of two, the division becomes an arithmetic shift. For any other total, a floor divider is built. The result is registered once, so a controller can replicate the unit across a wavefront or time-share it pixel by pixel.

Top module: `ed_pixel_unit`

## Requirements
- R1: The average error is floor((W_W·eW + W_NW·eNW + W_N·eN + W_NE·eNE) / WT), where WT = W_W+W_NW+W_N+W_NE. eW is the pixel to the left in the same row, eNW is up-left, eN is directly above and eNE is up-right. Defaults are 7, 1, 5, 3 (WT = 16).
- R2: When `in_first_col` is 1, the left and up-left errors count as zero whatever their input values.
- R3: When `in_first_row` is 1, the up-left, above and up-right errors count as zero whatever their input values.
- R4: When `in_last_col` is 1, the up-right error counts as zero whatever its input value.
- R5: The corrected value is the unsigned pixel plus the signed average. `out_bit` is 1 exactly when this value is at least 2^(PIX_W-1) (128 for 8 bits).
- R6: `out_err` is the corrected value minus 0 when `out_bit` is 0, or minus 2^PIX_W-1 (255) when `out_bit` is 1. It is a two's-complement value of ERR_W bits, and ERR_W ≥ PIX_W+2 guarantees it never wraps.
- R7: `out_valid` equals `in_valid` delayed by one clock. `out_bit` and `out_err` change only in the clock after a cycle with `in_valid` high, and hold otherwise.
- R8: While `rst` is high at a clock edge, `out_valid`, `out_bit` and `out_err` are cleared to 0.
- R9: When WT is not a power of two, the division still rounds toward minus infinity, so a sum of -1 gives an average of -1 rather than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel and neighbour errors are present |
| in_pix | input | PIX_W | Grayscale pixel, unsigned |
| in_err_w | input | ERR_W | Signed error of left neighbour |
| in_err_nw | input | ERR_W | Signed error of up-left neighbour |
| in_err_n | input | ERR_W | Signed error of neighbour above |
| in_err_ne | input | ERR_W | Signed error of up-right neighbour |
| in_first_col | input | 1 | Pixel is in the first column |
| in_last_col | input | 1 | Pixel is in the last column |
| in_first_row | input | 1 | Pixel is in the first row |
| out_valid | output | 1 | Result registered this cycle |
| out_bit | output | 1 | Halftone bit |
| out_err | output | ERR_W | Signed error of this pixel |

## Verification
The bench builds two copies of the unit, both with 8-bit pixels and 10-bit errors. The first uses the default weights 7, 1, 5, 3, so its division is a shift. The second uses weights 1, 1, 1, 0, which gives a total of three and brings in the floor divider and a zero-weight neighbour. Running negative error sums through both copies shows whether the divider rounds toward minus infinity, which a truncating divide would get wrong. Extreme errors of ±512 drive the corrected value to both ends of its range.

// File: rtl/halftone_pkg.sv
package halftone_pkg;

    typedef enum logic [1:0] {
        NB_LEFT    = 2'd0,
        NB_UPLEFT  = 2'd1,
        NB_ABOVE   = 2'd2,
        NB_UPRIGHT = 2'd3
    } nb_e;

    localparam int NB_COUNT = 4;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int log2_floor(input int v);
        int r;
        r = 0;
        while ((1 << (r + 1)) <= v) r++;
        return r;
    endfunction

endpackage

// File: rtl/ed_err_avg.sv
module ed_err_avg
    import halftone_pkg::*;
#(
    parameter int ERR_W = 10,
    parameter int W_W   = 7,
    parameter int W_NW  = 1,
    parameter int W_N   = 5,
    parameter int W_NE  = 3
) (
    input  logic signed [ERR_W-1:0] err_w,
    input  logic signed [ERR_W-1:0] err_nw,
    input  logic signed [ERR_W-1:0] err_n,
    input  logic signed [ERR_W-1:0] err_ne,
    input  logic                    first_col,
    input  logic                    last_col,
    input  logic                    first_row,
    output logic signed [ERR_W-1:0] avg
);
    localparam int WT    = W_W + W_NW + W_N + W_NE;
    localparam int SUM_W = ERR_W + $clog2(WT + 1) + 1;
    localparam int WGT [NB_COUNT] = '{W_W, W_NW, W_N, W_NE};

    logic signed [ERR_W-1:0] nb_err  [NB_COUNT];
    logic                    nb_live [NB_COUNT];
    logic signed [SUM_W-1:0] term    [NB_COUNT];
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        nb_err[NB_LEFT]     = err_w;
        nb_err[NB_UPLEFT]   = err_nw;
        nb_err[NB_ABOVE]    = err_n;
        nb_err[NB_UPRIGHT]  = err_ne;
        nb_live[NB_LEFT]    = !first_col;
        nb_live[NB_UPLEFT]  = !first_col && !first_row;
        nb_live[NB_ABOVE]   = !first_row;
        nb_live[NB_UPRIGHT] = !first_row && !last_col;
    end

    for (genvar k = 0; k < NB_COUNT; k++) begin : g_term
        logic signed [SUM_W-1:0] ext;
        localparam logic signed [SUM_W-1:0] WK = SUM_W'(WGT[k]);
        assign ext     = {{(SUM_W-ERR_W){nb_err[k][ERR_W-1]}}, nb_err[k]};
        assign term[k] = nb_live[k] ? ext * WK : '0;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NB_COUNT; k++) sum = sum + term[k];
    end

    if (is_pow2(WT)) begin : g_shift
        localparam int SH = log2_floor(WT);
        logic signed [SUM_W-1:0] shifted;
        assign shifted = sum >>> SH;
        assign avg     = shifted[ERR_W-1:0];
    end else begin : g_div
        localparam logic signed [SUM_W-1:0] WT_S = SUM_W'(WT);
        logic signed [SUM_W-1:0] quo, rem, flo;
        always_comb begin
            quo = sum / WT_S;
            rem = sum - quo * WT_S;
            flo = (sum < 0 && rem != 0) ? quo - 1 : quo;
        end
        assign avg = flo[ERR_W-1:0];
    end

    // R3 / R2: with every neighbour outside the image nothing may leak in
    always_comb begin
        if (first_row && first_col)
            p_edge_zero_r3: assert (avg == '0);
    end

endmodule

// File: rtl/ed_quantize.sv
module ed_quantize #(
    parameter int PIX_W = 8,
    parameter int ERR_W = 10
) (
    input  logic [PIX_W-1:0]        pix,
    input  logic signed [ERR_W-1:0] avg,
    output logic                    hbit,
    output logic signed [ERR_W-1:0] err
);
    localparam int CV_W = ((ERR_W > PIX_W) ? ERR_W : PIX_W) + 2;
    localparam logic signed [CV_W-1:0] THRESH = CV_W'(1 << (PIX_W - 1));
    localparam logic signed [CV_W-1:0] FULL   = CV_W'((1 << PIX_W) - 1);

    logic signed [CV_W-1:0] cpv, pix_x, avg_x, raw;

    always_comb begin
        pix_x = {{(CV_W-PIX_W){1'b0}}, pix};
        avg_x = {{(CV_W-ERR_W){avg[ERR_W-1]}}, avg};
        cpv   = pix_x + avg_x;
        hbit  = (cpv >= THRESH);
        raw   = hbit ? cpv - FULL : cpv;
        err   = raw[ERR_W-1:0];
    end

endmodule

// File: rtl/ed_pixel_unit.sv
module ed_pixel_unit
    import halftone_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int ERR_W = 10,
    parameter int W_W   = 7,
    parameter int W_NW  = 1,
    parameter int W_N   = 5,
    parameter int W_NE  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [PIX_W-1:0]        in_pix,
    input  logic signed [ERR_W-1:0] in_err_w,
    input  logic signed [ERR_W-1:0] in_err_nw,
    input  logic signed [ERR_W-1:0] in_err_n,
    input  logic signed [ERR_W-1:0] in_err_ne,
    input  logic                    in_first_col,
    input  logic                    in_last_col,
    input  logic                    in_first_row,
    output logic                    out_valid,
    output logic                    out_bit,
    output logic signed [ERR_W-1:0] out_err
);
    localparam logic signed [ERR_W-1:0] HALF = ERR_W'(1 << (PIX_W - 1));

    logic signed [ERR_W-1:0] avg;
    logic                    q_bit;
    logic signed [ERR_W-1:0] q_err;

    ed_err_avg #(
        .ERR_W(ERR_W), .W_W(W_W), .W_NW(W_NW), .W_N(W_N), .W_NE(W_NE)
    ) i_avg (
        .err_w(in_err_w), .err_nw(in_err_nw), .err_n(in_err_n), .err_ne(in_err_ne),
        .first_col(in_first_col), .last_col(in_last_col), .first_row(in_first_row),
        .avg(avg)
    );

    ed_quantize #(.PIX_W(PIX_W), .ERR_W(ERR_W)) i_quant (
        .pix(in_pix), .avg(avg), .hbit(q_bit), .err(q_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_err   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bit <= q_bit;
                out_err <= q_err;
            end
        end
    end

    p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_bit) && $stable(out_err)));
    p_err_hi_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_bit) |-> (out_err > -HALF));
    p_err_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_bit) |-> (out_err < HALF));

endmodule

// File: tb/test_ed_pixel_unit.sv
module test_ed_pixel_unit;
    localparam int PW = 8;
    localparam int EW = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic signed [EW-1:0] e_w = '0, e_nw = '0, e_n = '0, e_ne = '0;
    logic f_col = 1'b0, l_col = 1'b0, f_row = 1'b0;
    logic ov_a, ob_a, ov_b, ob_b;
    logic signed [EW-1:0] oe_a, oe_b;

    int checks = 0;
    int errors = 0;
    int exp_bit_a = 0, exp_err_a = 0, exp_bit_b = 0, exp_err_b = 0;

    always #10 clk = ~clk;

    ed_pixel_unit #(.PIX_W(PW), .ERR_W(EW)) i_ed_pixel_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .in_err_w(e_w), .in_err_nw(e_nw), .in_err_n(e_n), .in_err_ne(e_ne),
        .in_first_col(f_col), .in_last_col(l_col), .in_first_row(f_row),
        .out_valid(ov_a), .out_bit(ob_a), .out_err(oe_a));

    ed_pixel_unit #(.PIX_W(PW), .ERR_W(EW), .W_W(1), .W_NW(1), .W_N(1), .W_NE(0)) i_ed_pixel_unit_b (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .in_err_w(e_w), .in_err_nw(e_nw), .in_err_n(e_n), .in_err_ne(e_ne),
        .in_first_col(f_col), .in_last_col(l_col), .in_first_row(f_row),
        .out_valid(ov_b), .out_bit(ob_b), .out_err(oe_b));

    function automatic int fdiv(int s, int d);
        if (s >= 0) return s / d;
        return -((-s + d - 1) / d);
    endfunction

    // Behavioural model: returns {bit, err} through outputs
    task automatic model(input int w1, input int w2, input int w3, input int w4,
                         output int b, output int e);
        int sw, snw, sn, sne, s, cpv;
        sw  = f_col ? 0 : int'(e_w);
        snw = (f_col || f_row) ? 0 : int'(e_nw);
        sn  = f_row ? 0 : int'(e_n);
        sne = (f_row || l_col) ? 0 : int'(e_ne);
        s   = w1*sw + w2*snw + w3*sn + w4*sne;
        cpv = int'(in_pix) + fdiv(s, w1 + w2 + w3 + w4);
        b   = (cpv >= 128) ? 1 : 0;
        e   = b ? cpv - 255 : cpv;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int pix, input int a, input int b, input int c,
                        input int d, input bit fc, input bit lc, input bit fr, input string req);
        int nb, ne;
        @(negedge clk);
        in_valid = v; in_pix = PW'(pix);
        e_w = EW'(a); e_nw = EW'(b); e_n = EW'(c); e_ne = EW'(d);
        f_col = fc; l_col = lc; f_row = fr;
        if (v) begin
            model(7, 1, 5, 3, nb, ne); exp_bit_a = nb; exp_err_a = ne;
            model(1, 1, 1, 0, nb, ne); exp_bit_b = nb; exp_err_b = ne;
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "valid A", int'(ov_a), int'(v));
        chk(req, "bit A",   int'(ob_a), exp_bit_a);
        chk(req, "err A",   int'(oe_a), exp_err_a);
        chk(req, "valid B", int'(ov_b), int'(v));
        chk(req, "bit B",   int'(ob_b), exp_bit_b);
        chk(req, "err B",   int'(oe_b), exp_err_b);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8", "valid", int'(ov_a), 0);
        chk("R8", "bit",   int'(ob_a), 0);
        chk("R8", "err",   int'(oe_a), 0);
        chk("R8", "err B", int'(oe_b), 0);
        rst = 1'b0;

        // R1: interior weighted average
        step(1, 100, 16, 16, 16, 16, 0, 0, 0, "R1");
        step(1, 60, 40, -8, 24, 100, 0, 0, 0, "R1");
        // R5: threshold boundary
        step(1, 127, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 128, 0, 0, 0, 0, 0, 0, 0, "R5");
        step(1, 120, 10, 0, 0, 0, 0, 0, 0, "R5");
        // R2: first column ignores left and up-left
        step(1, 100, 400, 400, 0, 0, 1, 0, 0, "R2");
        // R3: first row ignores up-left, above, up-right
        step(1, 100, 0, 400, 400, 400, 0, 0, 1, "R3");
        step(1, 100, 300, 300, 300, 300, 1, 0, 1, "R3");
        // R4: last column ignores up-right
        step(1, 100, 0, 0, 0, 500, 0, 1, 0, "R4");
        // R6: error extremes
        step(1, 255, 511, 511, 511, 511, 0, 0, 0, "R6");
        step(1, 0, -512, -512, -512, -512, 0, 0, 0, "R6");
        step(1, 255, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R9: floor rounding of negative sums
        step(1, 128, -1, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 130, -4, 0, -1, 0, 0, 0, 0, "R9");
        // R7: idle cycles hold the result
        step(0, 0, 200, 200, 200, 200, 0, 0, 0, "R7");
        step(0, 255, -300, 0, 0, 0, 0, 0, 0, "R7");
        step(1, 90, 5, 5, 5, 5, 0, 0, 0, "R7");
        // mixed stream
        for (int k = 0; k < 300; k++) begin
            step(1'($urandom), int'($urandom_range(255)),
                 int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
                 int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
                 1'($urandom_range(3) == 0), 1'($urandom_range(3) == 0),
                 1'($urandom_range(3) == 0), "R1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule